// File: doc/BRIEF.md
# Timecode Ancillary Packet Builder

This block produces the words of a fixed 23-word, 8-bit ancillary data packet that carries a time-of-day timecode, for placement into the blanking interval of a video stream. The caller supplies the timecode as BCD digits for hours, minutes, seconds and frames. A one-cycle capture strobe freezes those digits into an internal snapshot. The caller then presents a word index, and the block returns the packet word at that position. The word comes back combinationally from the index and the snapshot.

The snapshot is the only source for the user data and for the checksum. Digits that change while a packet is being read out therefore cannot tear it. The capture logic is a two-state machine. **SNAP_EMPTY** is the state after reset: no capture has happened yet, and all digits read as zero. **SNAP_HELD** means a snapshot is stored. The transition *capture* moves SNAP_EMPTY to SNAP_HELD. The transition *recapture* is SNAP_HELD to SNAP_HELD on a later strobe, and it reloads the digits. With no strobe, each state holds. Only reset returns the machine to SNAP_EMPTY.

Top module: `tc_anc_packer`

## Requirements
- R1: Indices 0, 1 and 2 return 0x00, 0xFF and 0xFF; these three words form the flag that opens the packet.
- R2: Index 3 returns 0x60 (data identifier), index 4 returns 0x60 (secondary identifier) and index 5 returns 0x10 (count of 16 user words).
- R3: Indices 6 to 13 each carry one snapshot digit in bits 3:0, in this order: frame units, frame tens, second units, second tens, minute units, minute tens, hour units, hour tens. Frame tens and hour tens are 2 bits wide, and second tens and minute tens are 3 bits wide. Every bit above a digit's width is zero.
- R4: Indices 14 to 21 (user words 8 to 15) return 0x00.
- R5: Index 22 returns the 8-bit sum of the words at indices 3 to 21, with the carry dropped and no inversion.
- R6: Any index of 23 or above returns 0x00.
- R7: After reset the machine is in SNAP_EMPTY and every digit reads as zero, so indices 6 to 21 return 0x00 and index 22 returns 0xD0.
- R8: The digit inputs are ignored except at a clock edge where the capture strobe is high. Without such an edge, every packet word, including the checksum, keeps its value.
- R9: A strobe sampled at a clock edge changes the words right after that edge and not before it. A later strobe replaces the whole snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| capture_i | input | 1 | Snapshot strobe, sampled on the rising edge |
| fr_units_i | input | 4 | Frame units digit |
| fr_tens_i | input | 2 | Frame tens digit |
| sec_units_i | input | 4 | Second units digit |
| sec_tens_i | input | 3 | Second tens digit |
| min_units_i | input | 4 | Minute units digit |
| min_tens_i | input | 3 | Minute tens digit |
| hr_units_i | input | 4 | Hour units digit |
| hr_tens_i | input | 2 | Hour tens digit |
| word_idx_i | input | IDX_W (5) | Packet word index |
| word_o | output | 8 | Packet word at the index |

## Verification
Forty digit patterns are used. In each pattern the eight digit fields follow different strides, so a swapped field position, a wrong digit width or a missing field shows up as a mismatch at one particular index. After every capture the bench changes the digit inputs to unrelated values and then reads all 32 indices. This separates a real snapshot from a pass-through of the live inputs, and it exercises the out-of-range indices as well. Reading the packet before any capture separates the reset contents from a stale state. One run raises the strobe and reads the same index just before and just after the edge, to check that the update lands on that exact edge.

// File: rtl/tcpkt_pkg.sv
package tcpkt_pkg;

    localparam int DATA_W    = 8;
    localparam int FLAG_LEN  = 3;
    localparam int HDR_WORDS = 6;   // flag + two identifiers + count
    localparam int DIGITS    = 8;

    localparam logic [DATA_W-1:0] FLAG_W0  = 8'h00;
    localparam logic [DATA_W-1:0] FLAG_W12 = 8'hFF;
    localparam logic [DATA_W-1:0] ID_PRI   = 8'h60;
    localparam logic [DATA_W-1:0] ID_SEC   = 8'h60;

    // Snapshot of the timecode in BCD digits.
    typedef struct packed {
        logic [3:0] fr_u;
        logic [1:0] fr_t;
        logic [3:0] sc_u;
        logic [2:0] sc_t;
        logic [3:0] mn_u;
        logic [2:0] mn_t;
        logic [3:0] hr_u;
        logic [1:0] hr_t;
    } tc_digits_t;

    typedef enum logic {
        SNAP_EMPTY = 1'b0,
        SNAP_HELD  = 1'b1
    } snap_state_t;

    typedef enum logic [2:0] {
        RG_FLAG,
        RG_HDR,
        RG_USER,
        RG_SUM,
        RG_NONE
    } word_region_t;

endpackage

// File: rtl/tc_snapshot.sv
module tc_snapshot
    import tcpkt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       capture_i,
    input  tc_digits_t live_i,
    output tc_digits_t held_o
);

    snap_state_t state_q;
    snap_state_t state_d;
    tc_digits_t  store_q;

    // Next-state logic: capture / recapture / hold.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SNAP_EMPTY: if (capture_i) state_d = SNAP_HELD;
            SNAP_HELD:  state_d = SNAP_HELD;
            default:    state_d = SNAP_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SNAP_EMPTY;
        else        state_q <= state_d;
    end

    // Digit store, loaded only on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)         store_q <= '0;
        else if (capture_i) store_q <= live_i;
    end

    // Output process: nothing is presented until a snapshot exists.
    always_comb begin
        unique case (state_q)
            SNAP_HELD: held_o = store_q;
            default:   held_o = '0;
        endcase
    end

endmodule

// File: rtl/tc_checksum.sv
module tc_checksum #(
    parameter int N_WORDS = 19,
    parameter int W       = 8
) (
    input  logic [N_WORDS*W-1:0] words_i,
    output logic [W-1:0]         sum_o
);

    always_comb begin
        logic [W-1:0] acc;
        acc = '0;
        for (int i = 0; i < N_WORDS; i++) begin
            acc = acc + words_i[i*W +: W];
        end
        sum_o = acc;
    end

endmodule

// File: rtl/tc_word_sel.sv
module tc_word_sel
    import tcpkt_pkg::*;
#(
    parameter int USER_WORDS = 16,
    parameter int IDX_W      = 5
) (
    input  logic [IDX_W-1:0]             idx_i,
    input  logic [DATA_W-1:0]            count_i,
    input  logic [USER_WORDS*DATA_W-1:0] user_i,
    input  logic [DATA_W-1:0]            sum_i,
    output logic [DATA_W-1:0]            word_o
);

    localparam int SUM_IDX = HDR_WORDS + USER_WORDS;

    word_region_t     region;
    logic [IDX_W-1:0] user_off;

    always_comb begin
        if (idx_i < IDX_W'(FLAG_LEN))       region = RG_FLAG;
        else if (idx_i < IDX_W'(HDR_WORDS)) region = RG_HDR;
        else if (idx_i < IDX_W'(SUM_IDX))   region = RG_USER;
        else if (idx_i == IDX_W'(SUM_IDX))  region = RG_SUM;
        else                                region = RG_NONE;
    end

    assign user_off = idx_i - IDX_W'(HDR_WORDS);

    always_comb begin
        word_o = '0;
        unique case (region)
            RG_FLAG: word_o = (idx_i == '0) ? FLAG_W0 : FLAG_W12;
            RG_HDR: begin
                if (idx_i == IDX_W'(FLAG_LEN))          word_o = ID_PRI;
                else if (idx_i == IDX_W'(FLAG_LEN + 1)) word_o = ID_SEC;
                else                                    word_o = count_i;
            end
            RG_USER: begin
                for (int k = 0; k < USER_WORDS; k++) begin
                    if (user_off == IDX_W'(k)) word_o = user_i[k*DATA_W +: DATA_W];
                end
            end
            RG_SUM:  word_o = sum_i;
            RG_NONE: word_o = '0;
            default: word_o = '0;
        endcase
    end

endmodule

// File: rtl/tc_anc_packer.sv
module tc_anc_packer
    import tcpkt_pkg::*;
#(
    parameter int USER_WORDS = 16,
    parameter int IDX_W      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture_i,
    input  logic [3:0]       fr_units_i,
    input  logic [1:0]       fr_tens_i,
    input  logic [3:0]       sec_units_i,
    input  logic [2:0]       sec_tens_i,
    input  logic [3:0]       min_units_i,
    input  logic [2:0]       min_tens_i,
    input  logic [3:0]       hr_units_i,
    input  logic [1:0]       hr_tens_i,
    input  logic [IDX_W-1:0] word_idx_i,
    output logic [7:0]       word_o
);

    localparam int SUM_WORDS = 3 + USER_WORDS;   // identifiers, count, user data
    localparam logic [DATA_W-1:0] COUNT_WORD = DATA_W'(USER_WORDS);

    tc_digits_t live;
    tc_digits_t held;

    assign live = '{fr_u: fr_units_i,  fr_t: fr_tens_i,
                    sc_u: sec_units_i, sc_t: sec_tens_i,
                    mn_u: min_units_i, mn_t: min_tens_i,
                    hr_u: hr_units_i,  hr_t: hr_tens_i};

    tc_snapshot u_snap (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (capture_i),
        .live_i    (live),
        .held_o    (held)
    );

    // Digit words in transmit order, upper bits zero.
    logic [DATA_W-1:0] digit_word [DIGITS];
    always_comb begin
        digit_word[0] = DATA_W'(held.fr_u);
        digit_word[1] = DATA_W'(held.fr_t);
        digit_word[2] = DATA_W'(held.sc_u);
        digit_word[3] = DATA_W'(held.sc_t);
        digit_word[4] = DATA_W'(held.mn_u);
        digit_word[5] = DATA_W'(held.mn_t);
        digit_word[6] = DATA_W'(held.hr_u);
        digit_word[7] = DATA_W'(held.hr_t);
    end

    logic [USER_WORDS*DATA_W-1:0] user_flat;
    for (genvar g = 0; g < USER_WORDS; g++) begin : g_user
        if (g < DIGITS) begin : g_digit
            assign user_flat[g*DATA_W +: DATA_W] = digit_word[g];
        end else begin : g_pad
            assign user_flat[g*DATA_W +: DATA_W] = '0;
        end
    end

    logic [DATA_W-1:0] csum;
    tc_checksum #(.N_WORDS(SUM_WORDS), .W(DATA_W)) u_sum (
        .words_i ({user_flat, COUNT_WORD, ID_SEC, ID_PRI}),
        .sum_o   (csum)
    );

    tc_word_sel #(.USER_WORDS(USER_WORDS), .IDX_W(IDX_W)) u_sel (
        .idx_i   (word_idx_i),
        .count_i (COUNT_WORD),
        .user_i  (user_flat),
        .sum_i   (csum),
        .word_o  (word_o)
    );

endmodule

// File: rtl/tc_anc_packer_chk.sv
module tc_anc_packer_chk #(
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             capture_i,
    input logic [IDX_W-1:0] word_idx_i,
    input logic [7:0]       word_o
);

    assert_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (word_idx_i == IDX_W'(0)) |-> (word_o == 8'h00));

    assert_flag_hi_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (word_idx_i == IDX_W'(1) || word_idx_i == IDX_W'(2)) |-> (word_o == 8'hFF));

    assert_ident_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (word_idx_i == IDX_W'(3) || word_idx_i == IDX_W'(4)) |-> (word_o == 8'h60));

    assert_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (word_idx_i == IDX_W'(5)) |-> (word_o == 8'h10));

    assert_nibble_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (word_idx_i >= IDX_W'(6) && word_idx_i <= IDX_W'(13)) |-> (word_o[7:4] == 4'h0));

    assert_two_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (word_idx_i == IDX_W'(7) || word_idx_i == IDX_W'(13)) |-> (word_o[7:2] == 6'd0));

    assert_three_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (word_idx_i == IDX_W'(9) || word_idx_i == IDX_W'(11)) |-> (word_o[7:3] == 5'd0));

    assert_pad_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (word_idx_i >= IDX_W'(14) && word_idx_i <= IDX_W'(21)) |-> (word_o == 8'h00));

    assert_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (word_idx_i >= IDX_W'(23)) |-> (word_o == 8'h00));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(capture_i) && $stable(word_idx_i)) |-> $stable(word_o));

endmodule

bind tc_anc_packer tc_anc_packer_chk #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture_i  (capture_i),
    .word_idx_i (word_idx_i),
    .word_o     (word_o)
);

// File: tb/tc_anc_packer_test.sv
`timescale 1ns/1ps
module tc_anc_packer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       capture_i = 1'b0;
    logic [3:0] fr_units_i = '0;
    logic [1:0] fr_tens_i = '0;
    logic [3:0] sec_units_i = '0;
    logic [2:0] sec_tens_i = '0;
    logic [3:0] min_units_i = '0;
    logic [2:0] min_tens_i = '0;
    logic [3:0] hr_units_i = '0;
    logic [1:0] hr_tens_i = '0;
    logic [4:0] word_idx_i = '0;
    logic [7:0] word_o;

    int total = 0;
    int bad = 0;
    int dg [8];          // model of the snapshot, in transmit order

    always #2.5 clk = ~clk;   // 200 MHz

    tc_anc_packer uut (
        .clk(clk), .rst_n(rst_n), .capture_i(capture_i),
        .fr_units_i(fr_units_i), .fr_tens_i(fr_tens_i),
        .sec_units_i(sec_units_i), .sec_tens_i(sec_tens_i),
        .min_units_i(min_units_i), .min_tens_i(min_tens_i),
        .hr_units_i(hr_units_i), .hr_tens_i(hr_tens_i),
        .word_idx_i(word_idx_i), .word_o(word_o)
    );

    function automatic logic [7:0] expect_word(int i);
        int s;
        if (i == 0) return 8'h00;
        if (i == 1 || i == 2) return 8'hFF;
        if (i == 3 || i == 4) return 8'h60;
        if (i == 5) return 8'h10;
        if (i >= 6 && i <= 13) return 8'(dg[i-6]);
        if (i >= 14 && i <= 21) return 8'h00;
        if (i == 22) begin
            s = 8'hD0;
            for (int k = 0; k < 8; k++) s += dg[k];
            return 8'(s % 256);
        end
        return 8'h00;
    endfunction

    function automatic string req_of(int i);
        if (i <= 2)  return "R1";
        if (i <= 5)  return "R2";
        if (i <= 13) return "R3";
        if (i <= 21) return "R4";
        if (i == 22) return "R5";
        return "R6";
    endfunction

    task automatic check(string req, logic [7:0] got, logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s idx=%0d actual=%02h expected=%02h", req, word_idx_i, got, exp);
        end
    endtask

    task automatic drive_digits(int p);
        fr_units_i  = 4'(p % 10);
        fr_tens_i   = 2'(p % 3);
        sec_units_i = 4'((p * 3 + 1) % 10);
        sec_tens_i  = 3'(p % 6);
        min_units_i = 4'((p * 7 + 4) % 10);
        min_tens_i  = 3'((p + 2) % 6);
        hr_units_i  = 4'((p * 9 + 5) % 10);
        hr_tens_i   = 2'((p + 1) % 3);
    endtask

    task automatic model_from_inputs();
        dg[0] = fr_units_i;  dg[1] = fr_tens_i;
        dg[2] = sec_units_i; dg[3] = sec_tens_i;
        dg[4] = min_units_i; dg[5] = min_tens_i;
        dg[6] = hr_units_i;  dg[7] = hr_tens_i;
    endtask

    task automatic sweep_all(string tag);
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            word_idx_i = 5'(i);
            #1;
            check((tag == "") ? req_of(i) : tag, word_o, expect_word(i));
        end
    endtask

    task automatic pulse_capture();
        @(negedge clk);
        capture_i = 1'b1;
        @(negedge clk);
        capture_i = 1'b0;
    endtask

    initial begin
        #(5ns * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 8; k++) dg[k] = 0;
        drive_digits(7);           // live inputs nonzero during reset
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R7: reset contents, nothing captured yet
        sweep_all("R7");

        // R3 R4 R5 R6 R8: capture, disturb inputs, read all indices
        for (int p = 0; p < 40; p++) begin
            drive_digits(p);
            model_from_inputs();
            pulse_capture();
            drive_digits(p + 17);  // R8: ignored without a strobe
            sweep_all("");
        end

        // R9: edge placement of the snapshot update
        drive_digits(3);
        model_from_inputs();
        pulse_capture();
        drive_digits(8);
        @(negedge clk);
        word_idx_i = 5'd6;
        capture_i = 1'b1;
        #1;
        check("R9", word_o, expect_word(6));          // before the edge: old
        check("R9", 8'(0), 8'(0));
        @(posedge clk);
        #1;
        model_from_inputs();
        capture_i = 1'b0;
        check("R9", word_o, expect_word(6));          // after the edge: new
        word_idx_i = 5'd22;
        #1;
        check("R9", word_o, expect_word(22));

        // R8: a long stretch of changing inputs without a strobe
        for (int p = 0; p < 10; p++) begin
            @(negedge clk);
            drive_digits(p + 50);
        end
        sweep_all("R8");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule